// File: doc/BRIEF.md
# Message-Gated LED Access Sequencer

This block runs the processor-node side of a simple handshake that controls a shared LED output. Nothing writes the LEDs freely. A rising edge on the button input starts an exchange. The block sends a "button pressed" word to the host through an outgoing mailbox port and waits for the host's acknowledge. Only after that acknowledge does it write the LED port. It then announces "LED ready" with a second word, waits for a second acknowledge, and returns to idle.

Each message is one 32-bit word made of four bytes. Byte 0 sits in bits [7:0] and byte 3 in bits [31:24]. The bytes are:
- a type letter (byte 0);
- the node's number as an ASCII digit (byte 1);
- a data digit, or, in an acknowledge, the letter of the message being acknowledged (byte 2);
- a terminating zero (byte 3).

Both mailbox ports use a valid/ready handshake. Any reply other than the expected acknowledge ends the exchange and reports an error.

Top module: `led_access_seq`

## Requirements
- R1: After reset, tx_valid, rx_ready, led_we and err are low and led_data is zero.
- R2: A rising edge of btn while idle makes tx_valid high from the next cycle, with tx_data = {8'h00, 8'h30, 8'h30+NODE_ID, 8'h42}, the 'B' word.
- R3: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R4: After the 'B' word is accepted, tx_valid drops, rx_ready rises, and the block waits for the ACK word {8'h00, 8'h42, 8'h30+NODE_ID, 8'h41}.
- R5: On that ACK, led_data takes the led_val value sampled at the press and led_we is high for exactly one cycle, in the cycle after the ACK. led_we is never high at any other time.
- R6: In the same cycle as led_we, tx_valid presents the 'L' word {8'h00, 8'h30, 8'h30+NODE_ID, 8'h4C}.
- R7: After the 'L' word is accepted, an ACK word with 8'h4C in byte 2 returns the block to idle without an error, and a later press starts a new exchange.
- R8: A NACK word (byte 0 = 8'h4E), or any word other than the expected ACK, returns the block to idle, raises err for one cycle, and causes no LED write.
- R9: Button edges that occur while an exchange is in progress are ignored. A button still held high on the return to idle does not start a new exchange.
- R10: rx_ready is high only while waiting for an ACK, and tx_valid and rx_ready are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn | input | 1 | Button level, edge detected |
| led_val | input | LED_W | LED value sampled on a press |
| tx_data | output | 32 | Outgoing message word |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Mailbox accepts outgoing word |
| rx_data | input | 32 | Incoming message word |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Block accepts incoming word |
| led_data | output | LED_W | Shared LED value |
| led_we | output | 1 | One-cycle LED write strobe |
| err | output | 1 | One-cycle protocol error pulse |

## Verification
The hardest cases to reach are a second button edge that arrives in the middle of an exchange, and a button still held high when the exchange ends. Both must leave no trace. The bench drops and raises btn while the block waits for the first acknowledge, then keeps btn high through the rest of the exchange and for several idle cycles afterwards. It watches tx_valid the whole time. Error exits are reached from both waiting phases, the second one after the LED write has already taken place.

// File: rtl/led_access_seq.sv
`timescale 1ns/1ps
module led_access_seq #(
  parameter int NODE_ID = 0,
  parameter int LED_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn,
  input  logic [LED_W-1:0] led_val,
  output logic [31:0]      tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [31:0]      rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic [LED_W-1:0] led_data,
  output logic             led_we,
  output logic             err
);
  localparam logic [7:0] CH_B    = 8'h42;
  localparam logic [7:0] CH_L    = 8'h4C;
  localparam logic [7:0] CH_A    = 8'h41;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [7:0] CH_NODE = 8'(8'h30 + NODE_ID);

  localparam logic [31:0] MSG_B = {8'h00, CH_ZERO, CH_NODE, CH_B};
  localparam logic [31:0] MSG_L = {8'h00, CH_ZERO, CH_NODE, CH_L};
  localparam logic [31:0] ACK_B = {8'h00, CH_B, CH_NODE, CH_A};
  localparam logic [31:0] ACK_L = {8'h00, CH_L, CH_NODE, CH_A};

  typedef enum logic [2:0] {S_IDLE, S_SEND_B, S_WAIT_B, S_SEND_L, S_WAIT_L} state_t;

  state_t           st;
  logic             btn_q;
  logic [LED_W-1:0] pend;

  assign tx_valid = (st == S_SEND_B) || (st == S_SEND_L);
  assign tx_data  = (st == S_SEND_L) ? MSG_L : MSG_B;
  assign rx_ready = (st == S_WAIT_B) || (st == S_WAIT_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      btn_q    <= 1'b0;
      pend     <= '0;
      led_data <= '0;
      led_we   <= 1'b0;
      err      <= 1'b0;
    end else begin
      btn_q  <= btn;
      led_we <= 1'b0;
      err    <= 1'b0;
      case (st)
        S_IDLE:
          if (btn && !btn_q) begin
            pend <= led_val;
            st   <= S_SEND_B;
          end
        S_SEND_B:
          if (tx_ready) st <= S_WAIT_B;
        S_WAIT_B:
          if (rx_valid) begin
            if (rx_data == ACK_B) begin
              led_data <= pend;
              led_we   <= 1'b1;
              st       <= S_SEND_L;
            end else begin
              err <= 1'b1;
              st  <= S_IDLE;
            end
          end
        S_SEND_L:
          if (tx_ready) st <= S_WAIT_L;
        S_WAIT_L:
          if (rx_valid) begin
            if (rx_data != ACK_L) err <= 1'b1;
            st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/led_access_seq_chk.sv
`timescale 1ns/1ps
module led_access_seq_chk #(
  parameter int LED_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      tx_data,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [LED_W-1:0] led_data,
  input logic             led_we,
  input logic             err
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R3
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    led_we |=> !led_we); // R5
  AST_WE_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
    led_we |-> $past(rx_valid && rx_ready)); // R5
  AST_LED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !led_we |-> $stable(led_data)); // R5
  AST_WE_WITH_L: assert property (@(posedge clk) disable iff (!rst_n)
    led_we |-> tx_valid); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R8
  AST_ERR_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rx_valid && rx_ready) && !tx_valid && !rx_ready); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready)); // R10
endmodule

bind led_access_seq led_access_seq_chk #(.LED_W(LED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .led_data(led_data), .led_we(led_we), .err(err)
);

// File: tb/led_access_seq_tb.sv
`timescale 1ns/1ps
module led_access_seq_tb;
  localparam int NODE = 3;
  localparam int LW   = 4;
  localparam logic [31:0] W_B  = 32'h00303342;
  localparam logic [31:0] W_L  = 32'h0030334C;
  localparam logic [31:0] A_B  = 32'h00423341;
  localparam logic [31:0] A_L  = 32'h004C3341;
  localparam logic [31:0] N_B  = 32'h0042334E;

  logic clk = 0, rst_n = 0, btn = 0, tx_ready = 0, rx_valid = 0;
  logic [LW-1:0] led_val = '0;
  logic [31:0] rx_data = '0, tx_data;
  logic tx_valid, rx_ready, led_we, err;
  logic [LW-1:0] led_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  led_access_seq #(.NODE_ID(NODE), .LED_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn(btn), .led_val(led_val),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .led_data(led_data), .led_we(led_we), .err(err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic press(input logic [LW-1:0] v);
    @(negedge clk); led_val = v; btn = 1;
    @(negedge clk); btn = 0;
    chk("R2 tx_valid", {31'b0, tx_valid}, 1);
    chk("R2 B word", tx_data, W_B);
  endtask

  task automatic accept_tx(input logic [31:0] w, input int stall);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R3 valid held", {31'b0, tx_valid}, 1);
      chk("R3 data held", tx_data, w);
      chk("R5 no early write", {31'b0, led_we}, 0);
    end
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk("R4 tx dropped", {31'b0, tx_valid}, 0);
    chk("R4 rx_ready", {31'b0, rx_ready}, 1);
  endtask

  task automatic send_rx(input logic [31:0] w);
    rx_data = w; rx_valid = 1;
    @(negedge clk); rx_valid = 0; rx_data = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 0);
    chk("R1 led_we", {31'b0, led_we}, 0);
    chk("R1 err", {31'b0, err}, 0);
    chk("R1 led_data", {28'b0, led_data}, 0);
  endtask

  task automatic t_full(input logic [LW-1:0] v, input int stall);
    press(v);
    chk("R10 no rx_ready while sending", {31'b0, rx_ready}, 0);
    accept_tx(W_B, stall);
    send_rx(A_B);
    chk("R5 led_we", {31'b0, led_we}, 1);
    chk("R5 led_data", {28'b0, led_data}, {28'b0, v});
    chk("R6 tx_valid", {31'b0, tx_valid}, 1);
    chk("R6 L word", tx_data, W_L);
    @(negedge clk);
    chk("R5 strobe one cycle", {31'b0, led_we}, 0);
    accept_tx(W_L, stall);
    send_rx(A_L);
    chk("R7 idle tx", {31'b0, tx_valid}, 0);
    chk("R7 idle rx", {31'b0, rx_ready}, 0);
    chk("R7 no err", {31'b0, err}, 0);
  endtask

  task automatic t_nack;
    logic [LW-1:0] prev;
    prev = led_data;
    press(4'hC);
    accept_tx(W_B, 0);
    send_rx(N_B);
    chk("R8 err on NACK", {31'b0, err}, 1);
    chk("R8 no write", {31'b0, led_we}, 0);
    chk("R8 led held", {28'b0, led_data}, {28'b0, prev});
    chk("R8 idle", {31'b0, rx_ready | tx_valid}, 0);
    @(negedge clk);
    chk("R8 err one cycle", {31'b0, err}, 0);
    chk("R5 led still held", {28'b0, led_data}, {28'b0, prev});
  endtask

  task automatic t_bad_second;
    press(4'h6);
    accept_tx(W_B, 1);
    send_rx(A_B);
    @(negedge clk);
    accept_tx(W_L, 0);
    send_rx(A_B);
    chk("R8 err on wrong ACK", {31'b0, err}, 1);
    chk("R8 idle after wrong ACK", {31'b0, rx_ready | tx_valid}, 0);
    chk("R8 earlier write kept", {28'b0, led_data}, 28'h0 | 32'h6);
  endtask

  task automatic t_ignore;
    press(4'h9);
    accept_tx(W_B, 0);
    @(negedge clk); btn = 1;
    @(negedge clk); btn = 0;
    @(negedge clk); btn = 1;
    @(negedge clk);
    chk("R9 still waiting", {31'b0, rx_ready}, 1);
    chk("R9 no new send", {31'b0, tx_valid}, 0);
    send_rx(A_B);
    chk("R9 original value written", {28'b0, led_data}, 32'h9);
    @(negedge clk);
    accept_tx(W_L, 0);
    send_rx(A_L);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 held button ignored", {31'b0, tx_valid}, 0);
    end
    btn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_full(4'hA, 2);
    t_full(4'h5, 0);
    t_nack();
    t_bad_second();
    t_ignore();
    t_full(4'h3, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule